// File: doc/BRIEF.md
# Security-Banked Exception Priority Selector

This block keeps the pending state of the system exceptions and of a parameterised set of external interrupts. In every cycle it picks the exception that should be taken next and reports that exception's number. It also reports whether the handler runs in the Secure or the Non-secure state, and whether the winner is urgent enough to preempt the code that is running now. The supervisor call, the deferred-service request and the system-timer exception each exist as two independent copies, one per security state. Each copy has its own pending bit and its own priority byte, and the current security state decides which copy a request lands in.

Software reaches the block through a small word-addressed register port with a read path. Every access goes through either the Secure view or the Non-secure view. The Secure view is used only when the issuer is Secure and the alias flag is clear. A Non-secure issuer, or a Secure issuer that addresses the alias, gets the Non-secure view. Fields that belong to Secure software alone cannot be changed through the Non-secure view and read there as zero. These fields are the interrupt target bits, the NMI target bit, the security-fault priority, and the priority bytes of Secure-targeted interrupts.

The processor core drives the current execution priority and samples the winner. When the core begins a handler, it pulses `take`, which clears the pending bit of that winner.

Top module: `exc_bank_sel`

## Requirements
- R1: While `rst_n` is low, and afterwards until new stimulus arrives, no exception is pending, every priority byte is 0, every interrupt targets Secure, and the NMI targets Secure. `win_valid`, `preempt` and every read value are 0.
- R2: A pulse on `nmi_req` pends exception 2 at fixed priority -2. No enable or mask exists for it, so it wins over every exception that has a configurable priority. Its target state is the NMI target bit, which is bit 8 of word 0 and can be written only through the Secure view.
- R3: While `cur_pri` is -2 or lower and `in_nmi_ns` is low, `preempt` stays low whatever is pending.
- R4: A pulse on `sec_viol` pends a hard fault (exception 3) that always targets Secure. Its priority is -1, but it is -3 while `in_nmi_ns` is high, so it preempts a running Non-secure NMI handler.
- R5: A pulse on `svc_req` pends the supervisor-call copy (exception 11) of the state given by `cur_secure`. That copy targets the same state and uses the priority byte of its own bank.
- R6: A write to word 0 acts on the deferred-service copy (exception 14) of the view used. Bit 0 sets it and bit 1 clears it, and bit 1 wins when both are 1. Bit 0 of a read of word 0 returns the pending bit of the view's copy. A Secure issuer therefore reaches the Non-secure copy through the alias.
- R7: Word 1 holds the view bank's priority bytes: supervisor call in bits 7:0, deferred service in bits 15:8 and system timer in bits 23:16. Bits 31:24 hold the security-fault priority, which belongs to the Secure view only.
- R8: Word 2 holds one target bit per interrupt, where 1 means Non-secure. Interrupt i is exception 16+i, and `win_ns` follows its target bit.
- R9: Through the Non-secure view, writes to Secure-only fields leave them unchanged and reads of them return 0. Word 4+k holds the priorities of interrupts 4k to 4k+3, one byte each, with the lowest interrupt in the lowest byte. A byte whose interrupt targets Secure is one of these Secure-only fields.
- R10: A pulse on `sf_req` pends the security-check fault (exception 7), which always targets Secure.
- R11: Bit b of `tick_req` pends the system-timer copy (exception 15) of bank b, where bank 1 is Secure and bank 0 is Non-secure. This happens only if bit b of parameter `ST_BANKS` is set, and each copy has its own pending bit and priority.
- R12: The winner is the pending exception with the lowest priority value. A tie goes to the lower exception number, and between the two copies of one number the Secure copy wins. A configurable byte p counts as the priority value p.
- R13: `preempt` is high exactly when a winner exists and its priority is strictly lower than `cur_pri`.
- R14: A `take` pulse clears the pending bit of the current winner. A request for the same exception in the same cycle leaves it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_secure | input | 1 | Current security state (1 = Secure) |
| cur_pri | input | 10 | Current execution priority, signed |
| in_nmi_ns | input | 1 | A Non-secure NMI handler is running |
| nmi_req | input | 1 | NMI request pulse |
| sec_viol | input | 1 | Security violation, pends the Secure hard fault |
| sf_req | input | 1 | Security-check fault request pulse |
| svc_req | input | 1 | Supervisor-call request pulse |
| tick_req | input | 2 | System-timer request per bank (1 = Secure bank) |
| irq_req | input | N_IRQ | External interrupt request pulses |
| take | input | 1 | The core accepts the current winner |
| bus_wr | input | 1 | Register write strobe |
| bus_secure | input | 1 | The issuer is Secure |
| bus_alias | input | 1 | The access uses the Non-secure alias |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| win_valid | output | 1 | Some exception is pending |
| win_num | output | 8 | Exception number of the winner |
| win_ns | output | 1 | The winner's handler runs Non-secure |
| preempt | output | 1 | The winner preempts the current execution |

## Verification
Several properties are checked in every cycle:
- a running Secure NMI is never preempted;
- the hard fault and the security-check fault never report a Non-secure target;
- the reported winner is pending, and no pending candidate beats it;
- a `take` empties the winner's slot unless a request refilled it;
- writes through the Non-secure view leave the Secure-only fields alone.

Other behaviour is shown only by the bench's scenarios, which follow a behavioural model: the bank that an issuer or a security state selects, the tie orderings, the strictness of the preemption compare, clear winning over set in one write, and the values read back through each view.

// File: rtl/exc_bank_pkg.sv
package exc_bank_pkg;
  typedef logic signed [9:0] prio_t;

  // candidate slots, ordered by exception number, Secure copy first
  localparam int SLOT_NMI    = 0;
  localparam int SLOT_HF     = 1;
  localparam int SLOT_SF     = 2;
  localparam int SLOT_SVC_S  = 3;
  localparam int SLOT_SVC_NS = 4;
  localparam int SLOT_PSV_S  = 5;
  localparam int SLOT_PSV_NS = 6;
  localparam int SLOT_TCK_S  = 7;
  localparam int SLOT_TCK_NS = 8;
  localparam int SLOT_IRQ0   = 9;

  localparam prio_t PRI_NMI    = -10'sd2;
  localparam prio_t PRI_HF     = -10'sd1;
  localparam prio_t PRI_HF_ESC = -10'sd3;

  // exception number of a candidate slot
  function automatic int slot_num(int slot);
    case (slot)
      SLOT_NMI:                 return 2;
      SLOT_HF:                  return 3;
      SLOT_SF:                  return 7;
      SLOT_SVC_S, SLOT_SVC_NS:  return 11;
      SLOT_PSV_S, SLOT_PSV_NS:  return 14;
      SLOT_TCK_S, SLOT_TCK_NS:  return 15;
      default:                  return 16 + slot - SLOT_IRQ0;
    endcase
  endfunction

  function automatic prio_t cfg_pri(logic [7:0] p);
    return prio_t'({2'b00, p});
  endfunction

  // a Non-secure view may touch an interrupt byte only if that interrupt is Non-secure
  function automatic logic irq_lane_ok(logic view_s, logic tgt_ns);
    return view_s || tgt_ns;
  endfunction
endpackage

// File: rtl/exc_bank_regs.sv
module exc_bank_regs
  import exc_bank_pkg::*;
#(
  parameter int          N_IRQ    = 8,
  parameter int          ADDR_W   = 4,
  parameter logic [1:0]  ST_BANKS = 2'b11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_secure,
  input  logic                    bus_alias,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  input  logic [1:0]              psv_pend,
  output logic [31:0]             bus_rdata,
  output logic [1:0][7:0]         svc_pri,
  output logic [1:0][7:0]         psv_pri,
  output logic [1:0][7:0]         tick_pri,
  output logic [7:0]              sf_pri,
  output logic                    nmi_ns,
  output logic [N_IRQ-1:0]        irq_tgt_ns,
  output logic [N_IRQ-1:0][7:0]   irq_pri,
  output logic [1:0]              psv_set,
  output logic [1:0]              psv_clr
);
  localparam int PRI_BASE  = 4;
  localparam int PRI_WORDS = N_IRQ / 4;

  logic view_s, vb;
  logic hit_ctrl, hit_pri, hit_tgt, hit_ipri;
  int   word_sel;

  assign view_s   = bus_secure && !bus_alias;
  assign vb       = view_s;
  assign hit_ctrl = bus_addr == ADDR_W'(0);
  assign hit_pri  = bus_addr == ADDR_W'(1);
  assign hit_tgt  = bus_addr == ADDR_W'(2);
  assign hit_ipri = int'(bus_addr) >= PRI_BASE && int'(bus_addr) < PRI_BASE + PRI_WORDS;
  assign word_sel = int'(bus_addr) - PRI_BASE;

  // deferred-service controls of the view's bank; clear dominates set
  assign psv_set[1] = bus_wr && hit_ctrl &&  view_s && bus_wdata[0] && !bus_wdata[1];
  assign psv_set[0] = bus_wr && hit_ctrl && !view_s && bus_wdata[0] && !bus_wdata[1];
  assign psv_clr[1] = bus_wr && hit_ctrl &&  view_s && bus_wdata[1];
  assign psv_clr[0] = bus_wr && hit_ctrl && !view_s && bus_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_pri    <= '0;
      psv_pri    <= '0;
      tick_pri   <= '0;
      sf_pri     <= '0;
      nmi_ns     <= 1'b0;
      irq_tgt_ns <= '0;
      irq_pri    <= '0;
    end else if (bus_wr) begin
      if (hit_ctrl && view_s) nmi_ns <= bus_wdata[8];
      if (hit_pri) begin
        svc_pri[vb] <= bus_wdata[7:0];
        psv_pri[vb] <= bus_wdata[15:8];
        if (ST_BANKS[vb]) tick_pri[vb] <= bus_wdata[23:16];
        if (view_s) sf_pri <= bus_wdata[31:24];
      end
      if (hit_tgt && view_s) irq_tgt_ns <= bus_wdata[N_IRQ-1:0];
      for (int i = 0; i < N_IRQ; i++) begin
        if (hit_ipri && word_sel == i / 4 && irq_lane_ok(view_s, irq_tgt_ns[i]))
          irq_pri[i] <= bus_wdata[(i % 4) * 8 +: 8];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[0] = psv_pend[vb];
      bus_rdata[8] = view_s && nmi_ns;
    end
    if (hit_pri)
      bus_rdata = {view_s ? sf_pri : 8'h00, tick_pri[vb], psv_pri[vb], svc_pri[vb]};
    if (hit_tgt && view_s)
      bus_rdata[N_IRQ-1:0] = irq_tgt_ns;
    for (int i = 0; i < N_IRQ; i++) begin
      if (hit_ipri && word_sel == i / 4 && irq_lane_ok(view_s, irq_tgt_ns[i]))
        bus_rdata[(i % 4) * 8 +: 8] = irq_pri[i];
    end
  end

  // R9: the Non-secure view never alters Secure-only state
  a_r9_ns_view_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !view_s) |=> ($stable(irq_tgt_ns) && $stable(nmi_ns) && $stable(sf_pri)));
endmodule

// File: rtl/exc_bank_pend.sv
module exc_bank_pend
  import exc_bank_pkg::*;
#(
  parameter int          N_IRQ    = 8,
  parameter logic [1:0]  ST_BANKS = 2'b11,
  localparam int         NC       = SLOT_IRQ0 + N_IRQ,
  localparam int         IW       = $clog2(NC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur_secure,
  input  logic              nmi_req,
  input  logic              sec_viol,
  input  logic              sf_req,
  input  logic              svc_req,
  input  logic [1:0]        tick_req,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [1:0]        psv_set,
  input  logic [1:0]        psv_clr,
  input  logic              take,
  input  logic              win_valid,
  input  logic [IW-1:0]     win_idx,
  output logic [NC-1:0]     cand_valid,
  output logic [1:0]        psv_pend
);
  logic [NC-1:0] pend, set_vec, clr_vec;
  logic [1:0]    tick_set;

  for (genvar b = 0; b < 2; b++) begin : g_tick
    if (ST_BANKS[b]) begin : g_on
      assign tick_set[b] = tick_req[b];
    end else begin : g_off
      assign tick_set[b] = 1'b0;
    end
  end

  always_comb begin
    set_vec = '0;
    set_vec[SLOT_NMI]    = nmi_req;
    set_vec[SLOT_HF]     = sec_viol;
    set_vec[SLOT_SF]     = sf_req;
    set_vec[SLOT_SVC_S]  = svc_req &&  cur_secure;
    set_vec[SLOT_SVC_NS] = svc_req && !cur_secure;
    set_vec[SLOT_PSV_S]  = psv_set[1];
    set_vec[SLOT_PSV_NS] = psv_set[0];
    set_vec[SLOT_TCK_S]  = tick_set[1];
    set_vec[SLOT_TCK_NS] = tick_set[0];
    set_vec[SLOT_IRQ0 +: N_IRQ] = irq_req;
    clr_vec = '0;
    for (int k = 0; k < NC; k++)
      if (take && win_valid && win_idx == IW'(k)) clr_vec[k] = 1'b1;
    clr_vec[SLOT_PSV_S]  = clr_vec[SLOT_PSV_S]  | psv_clr[1];
    clr_vec[SLOT_PSV_NS] = clr_vec[SLOT_PSV_NS] | psv_clr[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_vec) | set_vec;
  end

  assign cand_valid = pend;
  assign psv_pend   = {pend[SLOT_PSV_S], pend[SLOT_PSV_NS]};

  for (genvar k = 0; k < NC; k++) begin : g_chk
    // R14: a taken slot empties unless refilled in the same cycle
    a_r14_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (take && win_valid && win_idx == IW'(k) && !set_vec[k]) |=> !pend[k]);
  end
endmodule

// File: rtl/exc_bank_arb.sv
module exc_bank_arb
  import exc_bank_pkg::*;
#(
  parameter int  N_IRQ = 8,
  localparam int NC    = SLOT_IRQ0 + N_IRQ,
  localparam int IW    = $clog2(NC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NC-1:0]  cand_valid,
  input  prio_t          cand_pri [NC],
  input  logic [NC-1:0]  cand_ns,
  output logic           win_valid,
  output logic [IW-1:0]  win_idx,
  output prio_t          win_pri,
  output logic           win_ns
);
  // ascending slot scan with strict compare: ties keep the earlier slot
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_pri   = '0;
    win_ns    = 1'b0;
    for (int k = 0; k < NC; k++) begin
      if (cand_valid[k] && (!win_valid || cand_pri[k] < win_pri)) begin
        win_valid = 1'b1;
        win_idx   = IW'(k);
        win_pri   = cand_pri[k];
        win_ns    = cand_ns[k];
      end
    end
  end

  // R12: the reported winner is pending
  a_r12_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> cand_valid[win_idx]);

  for (genvar k = 0; k < NC; k++) begin : g_chk
    // R12: no pending candidate is strictly more urgent than the winner
    a_r12_none_better: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && cand_valid[k]) |-> !(cand_pri[k] < win_pri));
  end
endmodule

// File: rtl/exc_bank_sel.sv
module exc_bank_sel
  import exc_bank_pkg::*;
#(
  parameter int          N_IRQ    = 8,
  parameter int          ADDR_W   = 4,
  parameter logic [1:0]  ST_BANKS = 2'b11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cur_secure,
  input  logic signed [9:0]   cur_pri,
  input  logic                in_nmi_ns,
  input  logic                nmi_req,
  input  logic                sec_viol,
  input  logic                sf_req,
  input  logic                svc_req,
  input  logic [1:0]          tick_req,
  input  logic [N_IRQ-1:0]    irq_req,
  input  logic                take,
  input  logic                bus_wr,
  input  logic                bus_secure,
  input  logic                bus_alias,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                win_valid,
  output logic [7:0]          win_num,
  output logic                win_ns,
  output logic                preempt
);
  localparam int NC = SLOT_IRQ0 + N_IRQ;
  localparam int IW = $clog2(NC);

  logic [1:0][7:0]       svc_pri, psv_pri, tick_pri;
  logic [7:0]            sf_pri;
  logic                  nmi_ns;
  logic [N_IRQ-1:0]      irq_tgt_ns;
  logic [N_IRQ-1:0][7:0] irq_pri;
  logic [1:0]            psv_set, psv_clr, psv_pend;
  logic [NC-1:0]         cand_valid, cand_ns;
  prio_t                 cand_pri [NC];
  logic [IW-1:0]         win_idx;
  prio_t                 win_pri;

  exc_bank_regs #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .ST_BANKS(ST_BANKS)) u_regs (
    .clk, .rst_n, .bus_wr, .bus_secure, .bus_alias, .bus_addr, .bus_wdata,
    .psv_pend, .bus_rdata, .svc_pri, .psv_pri, .tick_pri, .sf_pri, .nmi_ns,
    .irq_tgt_ns, .irq_pri, .psv_set, .psv_clr);

  exc_bank_pend #(.N_IRQ(N_IRQ), .ST_BANKS(ST_BANKS)) u_pend (
    .clk, .rst_n, .cur_secure, .nmi_req, .sec_viol, .sf_req, .svc_req, .tick_req,
    .irq_req, .psv_set, .psv_clr, .take, .win_valid, .win_idx, .cand_valid, .psv_pend);

  always_comb begin
    cand_pri[SLOT_NMI]    = PRI_NMI;
    cand_pri[SLOT_HF]     = in_nmi_ns ? PRI_HF_ESC : PRI_HF;
    cand_pri[SLOT_SF]     = cfg_pri(sf_pri);
    cand_pri[SLOT_SVC_S]  = cfg_pri(svc_pri[1]);
    cand_pri[SLOT_SVC_NS] = cfg_pri(svc_pri[0]);
    cand_pri[SLOT_PSV_S]  = cfg_pri(psv_pri[1]);
    cand_pri[SLOT_PSV_NS] = cfg_pri(psv_pri[0]);
    cand_pri[SLOT_TCK_S]  = cfg_pri(tick_pri[1]);
    cand_pri[SLOT_TCK_NS] = cfg_pri(tick_pri[0]);
    for (int i = 0; i < N_IRQ; i++) cand_pri[SLOT_IRQ0 + i] = cfg_pri(irq_pri[i]);
    cand_ns = '0;
    cand_ns[SLOT_NMI]    = nmi_ns;
    cand_ns[SLOT_SVC_NS] = 1'b1;
    cand_ns[SLOT_PSV_NS] = 1'b1;
    cand_ns[SLOT_TCK_NS] = 1'b1;
    cand_ns[SLOT_IRQ0 +: N_IRQ] = irq_tgt_ns;
  end

  exc_bank_arb #(.N_IRQ(N_IRQ)) u_arb (
    .clk, .rst_n, .cand_valid, .cand_pri, .cand_ns,
    .win_valid, .win_idx, .win_pri, .win_ns);

  assign win_num = 8'(slot_num(int'(win_idx)));
  assign preempt = win_valid && (win_pri < cur_pri);

  // R3: a Secure NMI handler cannot be preempted
  a_r3_nmi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_pri <= -10'sd2 && !in_nmi_ns) |-> !preempt);
  // R4: the hard fault is always handled Secure
  a_r4_hf_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_num == 8'd3) |-> !win_ns);
  // R10: the security-check fault is always handled Secure
  a_r10_sf_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_num == 8'd7) |-> !win_ns);
  // R13: a preempt request needs a winner
  a_r13_preempt_winner: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> win_valid);
endmodule

// File: tb/exc_bank_sel_bench.sv
module exc_bank_sel_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cur_secure = 1'b1;
  logic signed [9:0] cur_pri = 10'sd256;
  logic in_nmi_ns = 1'b0, nmi_req = 1'b0, sec_viol = 1'b0, sf_req = 1'b0, svc_req = 1'b0;
  logic [1:0] tick_req = '0;
  logic [N-1:0] irq_req = '0;
  logic take = 1'b0, bus_wr = 1'b0, bus_secure = 1'b1, bus_alias = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic win_valid, win_ns, preempt;
  logic [7:0] win_num;

  always #4 clk = ~clk;

  exc_bank_sel u_exc_bank_sel (
    .clk, .rst_n, .cur_secure, .cur_pri, .in_nmi_ns, .nmi_req, .sec_viol, .sf_req,
    .svc_req, .tick_req, .irq_req, .take, .bus_wr, .bus_secure, .bus_alias, .bus_addr,
    .bus_wdata, .bus_rdata, .win_valid, .win_num, .win_ns, .preempt);

  int checks = 0, errors = 0;
  string cur_req = "R1";

  // behavioural model; bank index 1 = Secure, 0 = Non-secure
  bit m_nmi, m_hf, m_sf, m_nmins;
  bit [1:0] m_svc, m_psv, m_tick;
  bit [N-1:0] m_irq, m_tgt;
  int p_svc[2], p_psv[2], p_tick[2], p_sf;
  int p_irq[N];
  longint best;
  bit e_v, e_ns;
  int e_num, e_pri;

  task automatic consider(bit v, int pri, int num, bit ns);
    longint key = longint'(pri + 8) * 4096 + num * 2 + (ns ? 1 : 0);
    if (v && key < best) begin
      best = key; e_v = 1; e_num = num; e_ns = ns; e_pri = pri;
    end
  endtask

  task automatic evaluate();
    best = 64'h7fff_ffff; e_v = 0; e_num = 0; e_ns = 0; e_pri = 0;
    consider(m_nmi, -2, 2, m_nmins);
    consider(m_hf, in_nmi_ns ? -3 : -1, 3, 0);
    consider(m_sf, p_sf, 7, 0);
    for (int b = 1; b >= 0; b--) begin
      consider(m_svc[b], p_svc[b], 11, b == 0);
      consider(m_psv[b], p_psv[b], 14, b == 0);
      consider(m_tick[b], p_tick[b], 15, b == 0);
    end
    for (int i = 0; i < N; i++) consider(m_irq[i], p_irq[i], 16 + i, m_tgt[i]);
  endtask

  function automatic logic [31:0] exp_read();
    bit vs = bus_secure && !bus_alias;
    int vb = vs ? 1 : 0;
    logic [31:0] r = '0;
    int a = int'(bus_addr);
    if (a == 0) begin r[0] = m_psv[vb]; r[8] = vs && m_nmins; end
    if (a == 1) r = {vs ? 8'(p_sf) : 8'h00, 8'(p_tick[vb]), 8'(p_psv[vb]), 8'(p_svc[vb])};
    if (a == 2 && vs) r[N-1:0] = m_tgt;
    for (int i = 0; i < N; i++)
      if (a == 4 + i / 4 && (vs || m_tgt[i])) r[(i % 4) * 8 +: 8] = 8'(p_irq[i]);
    return r;
  endfunction

  task automatic model_clock();
    bit vs = bus_secure && !bus_alias;
    int vb = vs ? 1 : 0;
    int a = int'(bus_addr);
    if (!rst_n) begin
      m_nmi = 0; m_hf = 0; m_sf = 0; m_nmins = 0; m_svc = 0; m_psv = 0; m_tick = 0;
      m_irq = 0; m_tgt = 0; p_sf = 0;
      for (int b = 0; b < 2; b++) begin p_svc[b] = 0; p_psv[b] = 0; p_tick[b] = 0; end
      for (int i = 0; i < N; i++) p_irq[i] = 0;
      return;
    end
    evaluate();
    if (take && e_v) begin
      case (e_num)
        2: m_nmi = 0;
        3: m_hf = 0;
        7: m_sf = 0;
        11: m_svc[e_ns ? 0 : 1] = 0;
        14: m_psv[e_ns ? 0 : 1] = 0;
        15: m_tick[e_ns ? 0 : 1] = 0;
        default: m_irq[e_num - 16] = 0;
      endcase
    end
    if (nmi_req) m_nmi = 1;
    if (sec_viol) m_hf = 1;
    if (sf_req) m_sf = 1;
    if (svc_req) m_svc[cur_secure ? 1 : 0] = 1;
    for (int b = 0; b < 2; b++) if (tick_req[b]) m_tick[b] = 1;
    for (int i = 0; i < N; i++) if (irq_req[i]) m_irq[i] = 1;
    if (bus_wr) begin
      if (a == 0) begin
        if (bus_wdata[1]) m_psv[vb] = 0; else if (bus_wdata[0]) m_psv[vb] = 1;
        if (vs) m_nmins = bus_wdata[8];
      end
      if (a == 1) begin
        p_svc[vb] = bus_wdata[7:0]; p_psv[vb] = bus_wdata[15:8]; p_tick[vb] = bus_wdata[23:16];
        if (vs) p_sf = bus_wdata[31:24];
      end
      for (int i = 0; i < N; i++)
        if (a == 4 + i / 4 && (vs || m_tgt[i])) p_irq[i] = bus_wdata[(i % 4) * 8 +: 8];
      if (a == 2 && vs) m_tgt = bus_wdata[N-1:0];
    end
  endtask

  task automatic compare();
    logic [31:0] er;
    bit ep;
    evaluate();
    er = exp_read();
    ep = e_v && (e_pri < int'(cur_pri));
    checks++;
    if (win_valid !== e_v || preempt !== ep || bus_rdata !== er ||
        (e_v && (int'(win_num) != e_num || win_ns !== e_ns))) begin
      errors++;
      $display("FAIL %s got v=%0b num=%0d ns=%0b pre=%0b rd=%h expected v=%0b num=%0d ns=%0b pre=%0b rd=%h",
               cur_req, win_valid, win_num, win_ns, preempt, bus_rdata,
               e_v, e_num, e_ns, ep, er);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_clock();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(bit sec, bit al, int a, logic [31:0] d);
    bus_secure = sec; bus_alias = al; bus_addr = 4'(a); bus_wdata = d; bus_wr = 1;
    cyc();
    bus_wr = 0;
  endtask

  task automatic rd(bit sec, bit al, int a);
    bus_secure = sec; bus_alias = al; bus_addr = 4'(a);
    cyc();
  endtask

  task automatic do_take();
    take = 1; cyc(); take = 0;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL R1 watchdog got hung run expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    repeat (3) cyc();
    rst_n = 1;
    rd(1, 0, 0); rd(1, 0, 1); rd(1, 0, 2); rd(0, 0, 1);

    // R7 banked priority bytes written through each view
    cur_req = "R7";
    wr(1, 0, 1, 32'h10_20_80_40);
    wr(0, 0, 1, 32'h00_28_90_30);
    rd(1, 0, 1); rd(1, 1, 1); rd(0, 0, 1);
    wr(1, 0, 4, 32'h60_20_50_20);
    wr(1, 0, 5, 32'h08_07_06_70);
    rd(1, 0, 4);

    // R11 and R12: banked timer copies, ties resolved by number then Secure copy
    cur_req = "R11";
    tick_req = 2'b11; irq_req = 8'h05; cyc(); tick_req = 0; irq_req = 0;
    cur_req = "R12";
    cur_pri = 10'sd256; cyc();
    do_take(); do_take(); do_take(); do_take(); cyc();

    // R13 strict preemption compare
    cur_req = "R13";
    irq_req = 8'h01; cyc(); irq_req = 0;
    cur_pri = 10'sd32; cyc();
    cur_pri = 10'sd33; cyc();
    cur_pri = 10'sd31; cyc();
    do_take(); cur_pri = 10'sd256;

    // R5 supervisor call lands in the current state's copy
    cur_req = "R5";
    cur_secure = 1; svc_req = 1; cyc(); svc_req = 0; cyc();
    cur_secure = 0; svc_req = 1; cyc(); svc_req = 0; cyc();
    do_take(); do_take(); cur_secure = 1;

    // R6 deferred-service controls per view, alias reaching the Non-secure copy
    cur_req = "R6";
    wr(0, 0, 0, 32'h1);
    rd(1, 0, 0); rd(1, 1, 0); rd(0, 0, 0);
    wr(1, 1, 0, 32'h2); rd(0, 0, 0);
    wr(1, 0, 0, 32'h3); rd(1, 0, 0);
    wr(1, 0, 0, 32'h1); rd(1, 0, 0); rd(1, 1, 0);
    wr(1, 0, 0, 32'h2);

    // R9 Non-secure view cannot touch Secure-only fields
    cur_req = "R9";
    wr(0, 0, 2, 32'hFF); rd(0, 0, 2); rd(1, 0, 2);
    wr(0, 0, 0, 32'h100); rd(1, 0, 0);
    wr(1, 1, 1, 32'hEE_28_90_30); rd(1, 0, 1);
    wr(0, 0, 4, 32'hAAAA_AAAA); rd(1, 0, 4);

    // R8 retargeting one interrupt, then the Non-secure view owns its byte
    cur_req = "R8";
    wr(1, 0, 2, 32'h02); rd(1, 0, 2);
    cur_req = "R9";
    wr(0, 0, 4, 32'hBBBB_BB0C); rd(0, 0, 4); rd(1, 0, 4);
    cur_req = "R8";
    irq_req = 8'h02; cyc(); irq_req = 0; cyc();
    do_take();

    // R2 NMI beats any configurable priority
    cur_req = "R2";
    irq_req = 8'h20; nmi_req = 1; cyc(); nmi_req = 0; irq_req = 0; cyc();
    // R3 Secure NMI running: a hard fault does not preempt it
    cur_req = "R3";
    do_take(); cur_pri = -10'sd2;
    sec_viol = 1; cyc(); sec_viol = 0; cyc();
    // R4 Non-secure NMI running: the Secure hard fault escalates and preempts
    cur_req = "R4";
    in_nmi_ns = 1; cyc();
    do_take(); in_nmi_ns = 0; cur_pri = 10'sd256;
    wr(1, 0, 0, 32'h100); rd(1, 0, 0); rd(0, 0, 0);
    cur_req = "R2";
    nmi_req = 1; cyc(); nmi_req = 0; cyc(); do_take(); do_take();

    // R10 security-check fault targets Secure
    cur_req = "R10";
    sf_req = 1; cyc(); sf_req = 0; cyc(); do_take();

    // R14 take together with a fresh request of the same exception
    cur_req = "R14";
    sf_req = 1; cyc(); sf_req = 0;
    sf_req = 1; take = 1; cyc(); sf_req = 0; take = 0; cyc();
    do_take(); cyc();

    // R1 again: reset mid-run wipes everything
    cur_req = "R1";
    irq_req = 8'h10; cyc(); irq_req = 0;
    rst_n = 0; cyc(); cyc(); rst_n = 1;
    rd(1, 0, 1); rd(1, 0, 2); rd(1, 0, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule